// File: doc/BRIEF.md
# Address-Tweaked Counter-Mode Line Cipher

This block turns one 512-bit cache line into its encrypted or decrypted form using counter mode. The line is split into four 128-bit chunks. For each chunk the block forms a 128-bit counter block from three inputs: the line's 56-bit version, the line-aligned part of its 39-bit physical address, and the chunk's position in the line. There is no free-running counter, so every chunk of every line at every version gets its own keystream.

The counter blocks go one per cycle to an external AES-128 engine over a valid/ready request port. Keystream words come back in issue order on a valid-only response port. Each word is XORed with the matching chunk of the captured line. Encryption and decryption use this same path. When all four chunks are done, the transformed line is offered to the consumer with a valid/ready handshake. A new line is taken only after that result has been consumed.

Top module: `ctr_line_cipher`

## Requirements
- R1: The counter block for chunk k is, from bit 127 down to bit 0: the 56-bit version, then physical address bits 38:6 (33 bits), then k as a 2-bit value, then 37 zero bits.
- R2: Chunk k is line bits 128k+127 down to 128k. Requests are issued for k = 0, 1, 2, 3 in that order. While the engine stays ready, a new request goes out on every cycle, starting the cycle after the line is accepted.
- R3: A request that is valid but not yet accepted keeps its valid signal high and its counter block unchanged.
- R4: Output chunk k equals input chunk k XOR the k-th keystream word received after the line was accepted. Feeding the result back in with the same version and address restores the original line.
- R5: The output valid signal rises in the cycle after the fourth keystream word arrives. Valid and the line data then hold steady until the consumer signals ready.
- R6: The input ready signal is high only when no line is in progress. While a line is being processed or its result is waiting, an input offered on the port is not accepted.
- R7: A keystream word that arrives when no line is in progress has no effect on later results.
- R8: While reset is asserted and just after it is released, input ready is high, output valid is low and request valid is low.
- R9: Exactly four requests go out per line. Address bits 5:0 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A line is offered |
| in_ready | output | 1 | Block is idle and takes the line |
| in_line | input | 512 | Plaintext or ciphertext line |
| in_addr | input | 39 | Physical byte address of the line |
| in_version | input | 56 | Version value of the line |
| aes_req_valid | output | 1 | Counter block is valid |
| aes_req_ready | input | 1 | Engine takes the counter block |
| aes_req_block | output | 128 | Counter block to encrypt |
| aes_rsp_valid | input | 1 | Keystream word is valid |
| aes_rsp_ks | input | 128 | Keystream word, in issue order |
| out_valid | output | 1 | Transformed line is valid |
| out_ready | input | 1 | Consumer takes the line |
| out_line | output | 512 | Transformed line |

## Verification
The first request is due in the cycle after the accepting edge. Each later request follows one cycle after the previous handshake. Output valid is due one cycle after the edge that samples the fourth keystream word, and input ready returns one cycle after the output handshake. The bench's model advances its state only on the handshakes it sees at each falling edge. It compares ready, valid, the counter block and the line against that model on every cycle, so each result is checked in exactly the cycle it is due. This holds under one-cycle and five-cycle engine latency and under a stalling request port.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  localparam int LINE_W  = 512;
  localparam int CHUNK_W = 128;
  localparam int NCHUNK  = LINE_W / CHUNK_W;
  localparam int VER_W   = 56;
  localparam int PA_W    = 39;
  localparam int LINE_LSB = 6;
  localparam int IDX_W   = $clog2(NCHUNK);
  localparam int CNT_W   = IDX_W + 1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } line_state_e;
endpackage

// File: rtl/ctr_block_fmt.sv
module ctr_block_fmt #(
  parameter int VER_W = 56,
  parameter int PA_W  = 39,
  parameter int LSB   = 6,
  parameter int IDX_W = 2,
  parameter int BLK_W = 128
) (
  input  logic [VER_W-1:0] ver,
  input  logic [PA_W-1:0]  addr,
  input  logic [IDX_W-1:0] idx,
  output logic [BLK_W-1:0] blk
);
  localparam int ADR_W = PA_W - LSB;
  localparam int PAD_W = BLK_W - VER_W - ADR_W - IDX_W;

  logic [ADR_W-1:0] line_adr;
  assign line_adr = addr[PA_W-1:LSB];
  assign blk = {ver, line_adr, idx, {PAD_W{1'b0}}};
endmodule

// File: rtl/ctr_issue_seq.sv
module ctr_issue_seq #(
  parameter int N = 4,
  localparam int IDX_W = $clog2(N),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  input  logic             req_ready,
  output logic             req_valid,
  output logic [IDX_W-1:0] idx,
  output logic [CNT_W-1:0] issued
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign req_valid = busy && (cnt_q < CNT_W'(N));
  assign idx       = cnt_q[IDX_W-1:0];
  assign issued    = cnt_q;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (start) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (req_valid && req_ready) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ctr_ks_merge.sv
module ctr_ks_merge #(
  parameter int N       = 4,
  parameter int CHUNK_W = 128,
  localparam int IDX_W  = $clog2(N),
  localparam int CNT_W  = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 busy,
  input  logic                 rsp_valid,
  input  logic [CHUNK_W-1:0]   rsp_ks,
  input  logic [N*CHUNK_W-1:0] src_line,
  output logic [N*CHUNK_W-1:0] res_line,
  output logic [CNT_W-1:0]     got,
  output logic                 all_done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             take;

  assign take     = busy && rsp_valid && (cnt_q < CNT_W'(N));
  assign all_done = (cnt_q == CNT_W'(N));
  assign got      = cnt_q;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (start) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (take) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  for (genvar k = 0; k < N; k++) begin : g_chunk
    logic [CHUNK_W-1:0] chunk_q;
    logic               chunk_en;
    assign chunk_en = take && (cnt_q[IDX_W-1:0] == IDX_W'(k));
    always_ff @(posedge clk) begin
      if (chunk_en) chunk_q <= src_line[k*CHUNK_W +: CHUNK_W] ^ rsp_ks;
    end
    assign res_line[k*CHUNK_W +: CHUNK_W] = chunk_q;
  end
endmodule

// File: rtl/ctr_line_cipher.sv
module ctr_line_cipher
  import ctr_pkg::*;
#(
  parameter int LW  = LINE_W,
  parameter int CW  = CHUNK_W,
  parameter int VW  = VER_W,
  parameter int AW  = PA_W,
  parameter int LSB = LINE_LSB,
  localparam int NC  = LW / CW,
  localparam int IW  = $clog2(NC),
  localparam int CNW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [LW-1:0] in_line,
  input  logic [AW-1:0] in_addr,
  input  logic [VW-1:0] in_version,
  output logic          aes_req_valid,
  input  logic          aes_req_ready,
  output logic [CW-1:0] aes_req_block,
  input  logic          aes_rsp_valid,
  input  logic [CW-1:0] aes_rsp_ks,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [LW-1:0] out_line
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  line_state_e st_q, st_d;
  logic        accept, release_line, all_done;
  logic [LW-1:0] line_q;
  logic [AW-1:0] addr_q;
  logic [VW-1:0] ver_q;
  logic [IW-1:0] idx;
  logic [CNW-1:0] issued, got;

  assign in_ready     = (st_q == ST_IDLE);
  assign accept       = in_valid && in_ready;
  assign out_valid    = (st_q == ST_BUSY) && all_done;
  assign release_line = out_valid && out_ready;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept)       st_d = ST_BUSY;
      ST_BUSY: if (release_line) st_d = ST_IDLE;
      default:                   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      line_q <= in_line;
      addr_q <= in_addr;
      ver_q  <= in_version;
    end
  end

  ctr_issue_seq #(.N(NC)) u_issue (
    .clk       (clk),
    .rst_n     (rst_q),
    .start     (accept),
    .busy      (st_q == ST_BUSY),
    .req_ready (aes_req_ready),
    .req_valid (aes_req_valid),
    .idx       (idx),
    .issued    (issued)
  );

  ctr_block_fmt #(.VER_W(VW), .PA_W(AW), .LSB(LSB), .IDX_W(IW), .BLK_W(CW)) u_fmt (
    .ver  (ver_q),
    .addr (addr_q),
    .idx  (idx),
    .blk  (aes_req_block)
  );

  ctr_ks_merge #(.N(NC), .CHUNK_W(CW)) u_merge (
    .clk       (clk),
    .rst_n     (rst_q),
    .start     (accept),
    .busy      (st_q == ST_BUSY),
    .rsp_valid (aes_rsp_valid),
    .rsp_ks    (aes_rsp_ks),
    .src_line  (line_q),
    .res_line  (out_line),
    .got       (got),
    .all_done  (all_done)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    aes_req_valid && !aes_req_ready |=> aes_req_valid && $stable(aes_req_block)); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid && !out_ready |=> out_valid && $stable(out_line)); // R5
  AST_NO_INPUT_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> !in_ready); // R6
  AST_RSP_WITHIN_ISSUED: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == ST_BUSY) |-> got <= issued); // R9
  AST_REQ_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    in_ready |-> !aes_req_valid && !out_valid); // R8
endmodule

// File: tb/sim_ctr_line_cipher.sv
module sim_ctr_line_cipher;
  localparam int CLK_P = 10;

  logic clk, rst_n;
  logic in_valid, in_ready;
  logic [511:0] in_line;
  logic [38:0]  in_addr;
  logic [55:0]  in_version;
  logic aes_req_valid, aes_req_ready;
  logic [127:0] aes_req_block;
  logic aes_rsp_valid;
  logic [127:0] aes_rsp_ks;
  logic out_valid, out_ready;
  logic [511:0] out_line;

  int n_run, n_fail;
  int cyc, lat, rdy_mode;
  bit spur, done;
  logic [127:0] pend_q[$];
  int pend_due[$];

  // model state
  bit m_busy;
  int m_iss, m_rsp;
  logic [511:0] m_line;
  logic [38:0]  m_addr;
  logic [55:0]  m_ver;
  logic [511:0] got;

  ctr_line_cipher u0 (.*);

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [127:0] mk_blk(logic [55:0] v, logic [38:0] a, int k);
    return {v, a[38:6], 2'(k), 37'b0};
  endfunction

  function automatic logic [127:0] ks_fn(logic [127:0] b);
    return {b[63:0] ^ 64'h9E3779B97F4A7C15, b[127:64] ^ 64'hC2B2AE3D27D4EB4F};
  endfunction

  function automatic logic [511:0] exp_line(logic [511:0] p, logic [38:0] a, logic [55:0] v);
    logic [511:0] r;
    for (int k = 0; k < 4; k++) r[k*128 +: 128] = p[k*128 +: 128] ^ ks_fn(mk_blk(v, a, k));
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // mock engine: drives ready pattern and in-order responses
  always @(posedge clk) begin
    #1;
    cyc++;
    aes_req_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    aes_rsp_valid = 1'b0;
    aes_rsp_ks    = '0;
    if (spur) begin
      aes_rsp_valid = 1'b1;
      aes_rsp_ks    = {4{32'hDEADBEEF}};
    end else if (pend_q.size() > 0 && pend_due[0] <= cyc) begin
      aes_rsp_valid = 1'b1;
      aes_rsp_ks    = ks_fn(pend_q.pop_front());
      void'(pend_due.pop_front());
    end
  end

  // reference model, compared every cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_iss = 0; m_rsp = 0;
    end else begin
      bit e_in_rdy, e_req_v, e_out_v;
      e_in_rdy = !m_busy;
      e_req_v  = m_busy && m_iss < 4;
      e_out_v  = m_busy && m_rsp == 4;
      chk(in_ready == e_in_rdy, "R6 in_ready", 512'(in_ready), 512'(e_in_rdy));
      chk(aes_req_valid == e_req_v, "R9 req_valid", 512'(aes_req_valid), 512'(e_req_v));
      chk(out_valid == e_out_v, "R5 out_valid", 512'(out_valid), 512'(e_out_v));
      if (e_req_v)
        chk(aes_req_block == mk_blk(m_ver, m_addr, m_iss), "R1 R2 req_block",
            512'(aes_req_block), 512'(mk_blk(m_ver, m_addr, m_iss)));
      if (e_out_v)
        chk(out_line == exp_line(m_line, m_addr, m_ver), "R4 out_line",
            out_line, exp_line(m_line, m_addr, m_ver));
      if (!m_busy) begin
        if (in_valid) begin
          m_busy = 1; m_iss = 0; m_rsp = 0;
          m_line = in_line; m_addr = in_addr; m_ver = in_version;
        end
      end else begin
        if (e_req_v && aes_req_ready) begin
          pend_q.push_back(mk_blk(m_ver, m_addr, m_iss));
          pend_due.push_back(cyc + lat);
          m_iss++;
        end
        if (aes_rsp_valid && m_rsp < 4) m_rsp++;
        if (e_out_v && out_ready) m_busy = 0;
      end
    end
  end

  task automatic send(input logic [511:0] l, input logic [38:0] a, input logic [55:0] v);
    @(posedge clk); #2;
    in_valid = 1'b1; in_line = l; in_addr = a; in_version = v;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic take(input int hold);
    do @(negedge clk); while (!out_valid);
    got = out_line;
    repeat (hold) @(negedge clk);
    @(posedge clk); #2 out_ready = 1'b1;
    @(posedge clk); #2 out_ready = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [511:0] la, lb, c;
    n_run = 0; n_fail = 0; cyc = 0; lat = 1; rdy_mode = 0; spur = 0; done = 0;
    in_valid = 0; in_line = '0; in_addr = '0; in_version = '0; out_ready = 0;
    aes_req_ready = 1; aes_rsp_valid = 0; aes_rsp_ks = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(in_ready && !out_valid && !aes_req_valid, "R8 reset", 512'({in_ready, out_valid, aes_req_valid}), 512'(3'b100));
    @(posedge clk); #3 rst_n = 1;
    repeat (3) @(negedge clk);
    chk(in_ready && !out_valid && !aes_req_valid, "R8 after reset", 512'({in_ready, out_valid, aes_req_valid}), 512'(3'b100));

    la = {16{32'h01234567}} ^ {8{64'hFEDCBA9876543210}};
    lb = {64{8'h5A}};

    // R2 R4: back-to-back issue, 1-cycle latency
    send(la, 39'h12_3456_78C0, 56'h00_1122_3344_5566);
    take(0);
    chk(got == exp_line(la, 39'h12_3456_78C0, 56'h00_1122_3344_5566), "R4 line a", got, exp_line(la, 39'h12_3456_78C0, 56'h00_1122_3344_5566));

    // R3 R5: stalling request port, longer latency, held output
    lat = 5; rdy_mode = 1;
    send(lb, 39'h7F_FFFF_FFC0, 56'hFF_FFFF_FFFF_FFFF);
    take(4);
    chk(got == exp_line(lb, 39'h7F_FFFF_FFC0, 56'hFF_FFFF_FFFF_FFFF), "R5 held line b", got, exp_line(lb, 39'h7F_FFFF_FFC0, 56'hFF_FFFF_FFFF_FFFF));

    // R6: second line offered while first result waits
    lat = 2; rdy_mode = 0;
    send(la, 39'h00_0000_0040, 56'h1);
    fork
      send(lb, 39'h00_0000_0080, 56'h2);
      take(6);
    join
    chk(got == exp_line(la, 39'h00_0000_0040, 56'h1), "R6 first kept", got, exp_line(la, 39'h00_0000_0040, 56'h1));
    take(0);
    chk(got == exp_line(lb, 39'h00_0000_0080, 56'h2), "R6 second line", got, exp_line(lb, 39'h00_0000_0080, 56'h2));

    // R7: stray keystream while idle
    repeat (2) @(posedge clk);
    #2 spur = 1;
    @(posedge clk); #2 spur = 0;
    send(lb, 39'h01_0203_0400, 56'h77);
    take(0);
    chk(got == exp_line(lb, 39'h01_0203_0400, 56'h77), "R7 after stray", got, exp_line(lb, 39'h01_0203_0400, 56'h77));

    // R4: round trip restores plaintext
    lat = 3; rdy_mode = 1;
    send(la, 39'h33_0000_1000, 56'hAB_CDEF);
    take(1);
    c = got;
    send(c, 39'h33_0000_1000, 56'hAB_CDEF);
    take(0);
    chk(got == la, "R4 round trip", got, la);

    // R9: low address bits ignored
    lat = 1; rdy_mode = 0;
    send(la, 39'h44_4444_4400, 56'h9);
    take(0);
    c = got;
    send(la, 39'h44_4444_443F, 56'h9);
    take(0);
    chk(got == c, "R9 low addr bits", got, c);
    chk(c == exp_line(la, 39'h44_4444_4400, 56'h9), "R1 layout", c, exp_line(la, 39'h44_4444_4400, 56'h9));

    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule